// File: doc/BRIEF.md
# JTAG Debug Interrupt Request Register

This block gives an external debugger a way to interrupt the on-chip processor through the JTAG port. A test access port controller, clocked by TCK, decodes TMS and keeps an 8-bit instruction register. When the debugger completes an instruction load whose opcode is the interrupt opcode, a sticky request flag is set in the processor clock domain. That flag drives a level interrupt output and is visible in a 16-bit processor register.

The processor reads that register to find the request. It writes a 0 to bit 0 to acknowledge it. Writing 1 to bit 0 does not set the flag. While the interrupt opcode is the current instruction, the debugger can scan the same register as a 32-bit data register. The register value sits in the low half and the high half is zero. Any other opcode selects a one-bit bypass path.

The set event crosses from TCK into the processor clock through a toggle and a two-stage synchronizer. The TAP reset condition crosses the same way. The flag read back over JTAG is synchronized into TCK.

Top module: `dbg_irq_tap`

## Requirements
- R1: The processor read value has bit 0 equal to the request flag and bits 15 to 1 always 0. After reset it reads 0.
- R2: Completing an instruction load (the Update-IR state) with opcode 8'h3C sets the flag. Loading any other opcode leaves the flag unchanged.
- R3: Each load of 8'h3C sets the flag once. A flag that the processor has cleared stays 0 while 8'h3C stays loaded and no new load occurs.
- R4: A processor write with bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves the flag as it was. Bits 15 to 1 of a write have no effect.
- R5: The interrupt output is high exactly while the flag is 1.
- R6: Asserting TRST (active low) clears the flag. Reaching Test-Logic-Reset by holding TMS high for five TCK cycles also clears it. Either reset makes the bypass opcode 8'hFF current.
- R7: While 8'h3C is current, Capture-DR loads a 32-bit scan register with the flag in bit 0 and zeros in bits 31 to 1. Shifting is LSB first, and TDI data appears on TDO after exactly 32 shifts.
- R8: Data shifted in through TDI on the 32-bit scan register never changes the flag.
- R9: With any opcode other than 8'h3C current, the data path is a one-bit bypass. It captures 0, and TDI appears on TDO after one shift.
- R10: Capture-IR loads 8'h01, so the first 8 bits shifted out of the instruction register, LSB first, are 1,0,0,0,0,0,0,0.
- R11: TDO and its output enable change on the falling edge of TCK. The enable is high only in Shift-IR and Shift-DR, and TDO is 0 whenever the enable is low.
- R12: When a set event and a processor clear land in the same processor cycle, the set wins and the flag is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low processor reset |
| cpu_we | input | 1 | Processor write strobe for the interrupt source register |
| cpu_wdata | input | 16 | Processor write data; only bit 0 acts |
| cpu_rdata | output | 16 | Processor read data: flag in bit 0, zeros above |
| irq | output | 1 | Level interrupt request to the processor |
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | JTAG reset, active low, sampled on TCK rising edge |
| tms | input | 1 | JTAG mode select |
| tdi | input | 1 | JTAG serial data in |
| tdo | output | 1 | JTAG serial data out, 0 when not enabled |
| tdo_oe | output | 1 | Output enable for TDO |

## Verification
The bench aims at a processor clear that arrives in the same cycle as a set event. It keeps clearing every cycle during an interrupt load, so a design where the clear wins would never raise the interrupt. It clears the flag while the interrupt opcode stays loaded and then runs more TCK cycles. A design that sets the flag from the current instruction level, and not from the update event, would raise it again. It scans 64 bits through the 32-bit path, so a path of the wrong length or one that writes TDI data into the flag shows up as wrong output bits or a changed flag. Both TAP reset routes are driven with the flag set, and random opcodes confirm that only 8'h3C sets the flag and that every other opcode bypasses.

// File: rtl/dbg_irq_pkg.sv
// Shared types for the debug interrupt TAP.
// Assumes the 16-state TAP encoding below; the reset state encodes as 0.
package dbg_irq_pkg;

    typedef enum logic [3:0] {
        TS_RESET    = 4'd0,
        TS_IDLE     = 4'd1,
        TS_SEL_DR   = 4'd2,
        TS_CAP_DR   = 4'd3,
        TS_SH_DR    = 4'd4,
        TS_EX1_DR   = 4'd5,
        TS_PAU_DR   = 4'd6,
        TS_EX2_DR   = 4'd7,
        TS_UPD_DR   = 4'd8,
        TS_SEL_IR   = 4'd9,
        TS_CAP_IR   = 4'd10,
        TS_SH_IR    = 4'd11,
        TS_EX1_IR   = 4'd12,
        TS_PAU_IR   = 4'd13,
        TS_EX2_IR   = 4'd14,
        TS_UPD_IR   = 4'd15
    } tap_state_t;

endpackage

// File: rtl/sync_bit.sv
// Multi-stage single-bit synchronizer.
// Assumes the input is a level (or a toggle) that is held stable for at least
// STAGES destination clocks; STAGES must be 2 or more.
module sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/tap_fsm.sv
// Test access port state machine, advanced on the TCK rising edge.
// Assumes trst_n is sampled synchronously on TCK; five TMS-high clocks
// reach the reset state from anywhere.
module tap_fsm
    import dbg_irq_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    // Hold the current controller state.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= TS_RESET;
        else         state <= nxt;
    end

    // Standard TMS-driven next-state decode.
    always_comb begin
        unique case (state)
            TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            default:   nxt = TS_RESET;
        endcase
    end

endmodule

// File: rtl/tap_regs.sv
// Instruction register, interrupt scan register, bypass bit and TDO driver.
// Assumes flag_tck is already synchronized to TCK. Produces a toggle that
// flips once per Update-IR of the interrupt opcode, for crossing to the CPU.
module tap_regs
    import dbg_irq_pkg::*;
#(
    parameter int             IR_W       = 8,
    parameter int             REG_W      = 16,
    parameter int             SCAN_W     = 32,
    parameter logic [IR_W-1:0] INT_OP    = 8'h3C,
    parameter logic [IR_W-1:0] IR_CAPTURE = 8'h01
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_t state,
    input  logic       flag_tck,
    output logic       tdo,
    output logic       tdo_oe,
    output logic       set_tgl
);

    localparam logic [IR_W-1:0] BYPASS_OP = {IR_W{1'b1}};
    localparam int              PAD_W     = SCAN_W - REG_W;

    logic [IR_W-1:0]   ir_sh;
    logic [IR_W-1:0]   ir_q;
    logic [SCAN_W-1:0] dr_sh;
    logic              byp_q;
    logic              int_sel;
    logic              shifting;
    logic              out_bit;

    assign int_sel  = (ir_q == INT_OP);
    assign shifting = (state == TS_SH_IR) || (state == TS_SH_DR);

    // Instruction capture, shift and update.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            ir_sh <= IR_CAPTURE;
            ir_q  <= BYPASS_OP;
        end else begin
            case (state)
                TS_RESET:  ir_q  <= BYPASS_OP;
                TS_CAP_IR: ir_sh <= IR_CAPTURE;
                TS_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                TS_UPD_IR: ir_q  <= ir_sh;
                default:   ;
            endcase
        end
    end

    // Flip the crossing toggle once per interrupt-opcode update.
    always_ff @(posedge tck) begin
        if (!trst_n)
            set_tgl <= 1'b0;
        else if (state == TS_UPD_IR && ir_sh == INT_OP)
            set_tgl <= ~set_tgl;
    end

    // Data path: 32-bit interrupt scan register or single bypass bit.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            dr_sh <= '0;
            byp_q <= 1'b0;
        end else if (state == TS_CAP_DR) begin
            if (int_sel) dr_sh <= {{PAD_W{1'b0}}, {(REG_W-1){1'b0}}, flag_tck};
            else         byp_q <= 1'b0;
        end else if (state == TS_SH_DR) begin
            if (int_sel) dr_sh <= {tdi, dr_sh[SCAN_W-1:1]};
            else         byp_q <= tdi;
        end
    end

    // Select the serial bit for the active shift path.
    always_comb begin
        if (state == TS_SH_IR) out_bit = ir_sh[0];
        else if (int_sel)      out_bit = dr_sh[0];
        else                   out_bit = byp_q;
    end

    // Launch TDO and its enable on the falling edge of TCK.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shifting;
            tdo    <= shifting & out_bit;
        end
    end

endmodule

// File: rtl/irq_flag.sv
// Sticky interrupt request flag in the CPU clock domain.
// Assumes set_tgl and tap_rst come from TCK registers. Priority, highest
// first: TAP reset, set event, CPU clear.
module irq_flag #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_tgl,
    input  logic tap_rst,
    input  logic clr_req,
    output logic flag,
    output logic set_evt,
    output logic tlr_evt
);

    logic tgl_s;
    logic tgl_d;

    sync_bit #(.STAGES(SYNC_STAGES)) u_sync_tgl (
        .clk(clk), .rst_n(rst_n), .d(set_tgl), .q(tgl_s)
    );

    sync_bit #(.STAGES(SYNC_STAGES)) u_sync_rst (
        .clk(clk), .rst_n(rst_n), .d(tap_rst), .q(tlr_evt)
    );

    // Remember the last synchronized toggle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tgl_d <= 1'b0;
        else        tgl_d <= tgl_s;
    end

    assign set_evt = tgl_s ^ tgl_d;

    // Update the request flag by priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (tlr_evt) flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

endmodule

// File: rtl/dbg_irq_tap.sv
// Top: JTAG-driven debug interrupt request register.
// Assumes clk and tck are unrelated; all crossings go through sync_bit.
module dbg_irq_tap
    import dbg_irq_pkg::*;
#(
    parameter int              REG_W       = 16,
    parameter int              SCAN_W      = 32,
    parameter int              IR_W        = 8,
    parameter logic [IR_W-1:0] INT_OP      = 8'h3C,
    parameter logic [IR_W-1:0] IR_CAPTURE  = 8'h01,
    parameter int              SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    output logic             irq,
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_oe
);

    tap_state_t state;
    logic       set_tgl;
    logic       tap_rst;
    logic       flag;
    logic       flag_tck;
    logic       set_evt;
    logic       tlr_evt;
    logic       clr_req;
    logic       wdata_unused;

    assign tap_rst      = (state == TS_RESET);
    assign clr_req      = cpu_we & ~cpu_wdata[0];
    assign wdata_unused = ^cpu_wdata[REG_W-1:1];

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
    );

    tap_regs #(
        .IR_W(IR_W), .REG_W(REG_W), .SCAN_W(SCAN_W),
        .INT_OP(INT_OP), .IR_CAPTURE(IR_CAPTURE)
    ) u_regs (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
        .flag_tck(flag_tck), .tdo(tdo), .tdo_oe(tdo_oe), .set_tgl(set_tgl)
    );

    irq_flag #(.SYNC_STAGES(SYNC_STAGES)) u_flag (
        .clk(clk), .rst_n(rst_n), .set_tgl(set_tgl), .tap_rst(tap_rst),
        .clr_req(clr_req), .flag(flag), .set_evt(set_evt), .tlr_evt(tlr_evt)
    );

    sync_bit #(.STAGES(SYNC_STAGES)) u_sync_flag (
        .clk(tck), .rst_n(trst_n), .d(flag), .q(flag_tck)
    );

    assign cpu_rdata = {{(REG_W-1){1'b0}}, flag};
    assign irq       = flag;

endmodule

// File: rtl/dbg_irq_tap_chk.sv
// Assertion checker bound into dbg_irq_tap.
module dbg_irq_tap_chk #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tck,
    input logic             trst_n,
    input logic             cpu_we,
    input logic [REG_W-1:0] cpu_wdata,
    input logic [REG_W-1:0] cpu_rdata,
    input logic             irq,
    input logic             tdo,
    input logic             tdo_oe,
    input logic             set_evt,
    input logic             tlr_evt
);

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cpu_rdata[REG_W-1:1] == '0); // R1
    AST_IRQ_IS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq == cpu_rdata[0]); // R5
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (set_evt && !tlr_evt) |=> irq); // R2
    AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $past(set_evt)); // R3
    AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (cpu_we && !cpu_wdata[0] && !set_evt) |=> !irq); // R4
    AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (cpu_we && cpu_wdata[0] && irq && !tlr_evt) |=> irq); // R4
    AST_TAP_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) tlr_evt |=> !irq); // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (set_evt && !tlr_evt && cpu_we && !cpu_wdata[0]) |=> irq); // R12
    AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!trst_n) !tdo_oe |-> !tdo); // R11

endmodule

bind dbg_irq_tap dbg_irq_tap_chk #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tck(tck), .trst_n(trst_n),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .irq(irq), .tdo(tdo), .tdo_oe(tdo_oe),
    .set_evt(set_evt), .tlr_evt(tlr_evt)
);

// File: tb/tb_dbg_irq_tap.sv
module tb_dbg_irq_tap;

    localparam logic [7:0] INT_OP = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        irq;
    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        tdo_oe;

    int total = 0;
    int bad   = 0;
    int oe_bad = 0;
    logic exp_flag = 1'b0;

    dbg_irq_tap dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .irq(irq), .tck(tck), .trst_n(trst_n),
        .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe)
    );

    always #2 clk = ~clk;

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One TCK period; returns TDO/enable as launched at the previous falling edge.
    task automatic jclk(input logic m, input logic d, output logic o, output logic e);
        tms = m; tdi = d;
        #2; o = tdo; e = tdo_oe;
        #6 tck = 1'b1;
        #8 tck = 1'b0;
    endtask

    task automatic idle(input int n);
        logic o, e;
        for (int i = 0; i < n; i++) jclk(1'b0, 1'b0, o, e);
    endtask

    task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap);
        logic o, e;
        jclk(1'b1, 1'b0, o, e); jclk(1'b1, 1'b0, o, e);
        jclk(1'b0, 1'b0, o, e); jclk(1'b0, 1'b0, o, e);
        for (int i = 0; i < 8; i++) begin
            jclk(i == 7, op[i], o, e);
            cap[i] = o;
            if (!e) oe_bad++;
        end
        jclk(1'b1, 1'b0, o, e); jclk(1'b0, 1'b0, o, e);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o, e;
        dout = '0;
        jclk(1'b1, 1'b0, o, e); jclk(1'b0, 1'b0, o, e); jclk(1'b0, 1'b0, o, e);
        for (int i = 0; i < n; i++) begin
            jclk(i == n - 1, din[i], o, e);
            dout[i] = o;
            if (!e) oe_bad++;
        end
        jclk(1'b1, 1'b0, o, e); jclk(1'b0, 1'b0, o, e);
    endtask

    task automatic cpu_write(input logic [15:0] d);
        @(negedge clk); cpu_we = 1'b1; cpu_wdata = d;
        @(negedge clk); cpu_we = 1'b0; cpu_wdata = '0;
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    // Expected DR scan output for an n-bit scan from the requirements (R7, R9).
    function automatic logic [63:0] dr_expect(input logic sel, input logic f, input logic [63:0] din, input int n);
        logic [63:0] r;
        r = '0;
        if (sel) r = (din << 32) | {63'b0, f};
        else     r = din << 1;
        if (n < 64) r = r & ((64'd1 << n) - 64'd1);
        return r;
    endfunction

    function automatic logic flag_after_op(input logic prev, input logic [7:0] op);
        return prev | (op == INT_OP);
    endfunction

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  cap;
        logic [63:0] din, dout;
        logic [7:0]  cur_op;
        logic        o, e, seen;
        void'($urandom(32'd4242));

        // Reset both domains.
        jclk(1'b1, 1'b0, o, e); jclk(1'b1, 1'b0, o, e); jclk(1'b1, 1'b0, o, e);
        repeat (4) @(negedge clk);
        rst_n = 1'b1; trst_n = 1'b1;
        jclk(1'b0, 1'b0, o, e);
        settle();
        check(cpu_rdata == 16'h0, "R1 reset read", cpu_rdata, 0);
        check(irq == 1'b0, "R5 reset irq", irq, 0);
        jclk(1'b0, 1'b0, o, e);
        check(!e && !o, "R11 idle tdo quiet", {e, o}, 0);

        // Default after reset is bypass (R6, R9).
        din = 64'h5A;
        scan_dr(8, din, dout);
        check(dout == dr_expect(1'b0, 1'b0, din, 8), "R9 bypass after reset", dout, dr_expect(1'b0, 1'b0, din, 8));

        // Load interrupt opcode; capture value shifted out (R10), flag set (R2).
        scan_ir(INT_OP, cap);
        check(cap == 8'h01, "R10 IR capture", cap, 8'h01);
        settle();
        exp_flag = 1'b1;
        check(cpu_rdata == 16'h0001, "R2 set by update", cpu_rdata, 16'h0001);
        check(irq == 1'b1, "R5 irq follows flag", irq, 1);

        // 64-bit scan through 32-bit register (R7), flag untouched (R8).
        idle(3);
        din = {$urandom, $urandom};
        scan_dr(64, din, dout);
        check(dout == dr_expect(1'b1, 1'b1, din, 64), "R7 scan length and capture", dout, dr_expect(1'b1, 1'b1, din, 64));
        settle();
        check(cpu_rdata == 16'h0001, "R8 shift leaves flag", cpu_rdata, 16'h0001);

        // Write with bit0=1 keeps; upper bits ignored (R4, R1).
        cpu_write(16'hFFFF);
        settle();
        check(cpu_rdata == 16'h0001, "R4 write one keeps", cpu_rdata, 16'h0001);
        cpu_write(16'hFFFE);
        settle();
        exp_flag = 1'b0;
        check(cpu_rdata == 16'h0000, "R4 write zero clears", cpu_rdata, 0);
        check(irq == 1'b0, "R5 irq drops", irq, 0);

        // Opcode still loaded: no re-set (R3); captured 0 (R7).
        idle(40);
        settle();
        check(cpu_rdata == 16'h0000, "R3 no re-set while held", cpu_rdata, 0);
        din = {32'h0, $urandom};
        scan_dr(32, din, dout);
        check(dout == dr_expect(1'b1, 1'b0, din, 32), "R7 capture of cleared flag", dout, dr_expect(1'b1, 1'b0, din, 32));

        // A second load sets again (R3).
        scan_ir(INT_OP, cap);
        settle();
        check(cpu_rdata == 16'h0001, "R3 second update sets", cpu_rdata, 16'h0001);

        // TMS-high path to reset clears and selects bypass (R6).
        for (int i = 0; i < 5; i++) jclk(1'b1, 1'b0, o, e);
        jclk(1'b0, 1'b0, o, e);
        settle();
        check(cpu_rdata == 16'h0000, "R6 TMS reset clears", cpu_rdata, 0);
        din = 64'hC3;
        scan_dr(8, din, dout);
        check(dout == dr_expect(1'b0, 1'b0, din, 8), "R6 bypass after TMS reset", dout, dr_expect(1'b0, 1'b0, din, 8));

        // TRST clears (R6).
        scan_ir(INT_OP, cap);
        settle();
        check(cpu_rdata == 16'h0001, "R2 set before TRST", cpu_rdata, 16'h0001);
        trst_n = 1'b0;
        jclk(1'b0, 1'b0, o, e); jclk(1'b0, 1'b0, o, e);
        trst_n = 1'b1;
        jclk(1'b0, 1'b0, o, e);
        settle();
        check(cpu_rdata == 16'h0000, "R6 TRST clears", cpu_rdata, 0);

        // Collision: continuous clears during a set (R12).
        seen = 1'b0;
        fork
            scan_ir(INT_OP, cap);
            begin
                for (int i = 0; i < 120; i++) begin
                    @(negedge clk);
                    cpu_we = 1'b1; cpu_wdata = 16'h0;
                    if (irq) seen = 1'b1;
                end
                @(negedge clk); cpu_we = 1'b0;
            end
        join
        settle();
        check(seen == 1'b1, "R12 set wins over clear", seen, 1);
        check(cpu_rdata == 16'h0000, "R12 later clear takes", cpu_rdata, 0);
        exp_flag = 1'b0;
        cur_op = INT_OP;

        // Random opcodes, scans and CPU writes (R2, R4, R7, R9).
        for (int k = 0; k < 24; k++) begin
            logic [7:0] op;
            logic [15:0] wd;
            op = ($urandom % 4 == 0) ? INT_OP : 8'($urandom);
            scan_ir(op, cap);
            check(cap == 8'h01, "R10 IR capture random", cap, 8'h01);
            exp_flag = flag_after_op(exp_flag, op);
            cur_op = op;
            settle();
            check(cpu_rdata == {15'b0, exp_flag}, "R2 random opcode", cpu_rdata, {15'b0, exp_flag});
            idle(3);
            din = {$urandom, $urandom};
            scan_dr(40, din, dout);
            check(dout == dr_expect(cur_op == INT_OP, exp_flag, din, 40),
                  (cur_op == INT_OP) ? "R7 random scan" : "R9 random bypass",
                  dout, dr_expect(cur_op == INT_OP, exp_flag, din, 40));
            wd = 16'($urandom);
            cpu_write(wd);
            exp_flag = exp_flag & wd[0];
            settle();
            check(irq == exp_flag, "R4 random write", irq, exp_flag);
        end

        check(oe_bad == 0, "R11 enable during shift", oe_bad, 0);
        jclk(1'b0, 1'b0, o, e);
        check(!e && !o, "R11 quiet after shifts", {e, o}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule